// File: doc/BRIEF.md
# Outbound Address Window Translator

This block holds a small table of outbound windows that move CPU-side addresses into PCI-side address space. Each window has a source base, a power-of-two size, an enable, a translated base, and two type fields: a resource kind (memory or I/O) and a transaction-layer packet type. Software or boot logic fills the table through a write-only register port. Each entry sits at a fixed stride and has fixed word offsets inside it.

A requester presents a 32-bit CPU address on the lookup port. One cycle later the block returns a hit flag, the translated address and the type fields of the lowest-numbered enabled window that covers the address. On a miss the address comes back unchanged with both type fields cleared. The upper 32-bit halves of the source and translated bases can be written and are kept, but they take no part in matching or translation. All addresses are treated as 32-bit.

Top module: `xlat_window_table`

## Requirements
- R1: An address inside an enabled window returns hit=1, and the result address is the translated base with its in-window offset bits replaced by those of the lookup address.
- R2: Bits 6:1 of the source-low word hold a size code c, and the window spans 2^(c+1) bytes. The source base is given by the source-low bits above the window. The first and last byte of a window hit; the byte just below and the byte just past it miss.
- R3: When several enabled windows cover an address, the entry with the lowest index supplies the result.
- R4: Bit 0 of the source-low word enables the entry. A disabled entry never hits, whatever its other contents.
- R5: Windows are never smaller than 4 KiB. Size codes below 11 act as code 11, and source-low bits 11:0 never form part of the base. Codes of 31 or more cover the whole 32-bit space.
- R6: The source-high and translated-high words (offsets 0x04 and 0x0C) are stored but have no effect on hit, address or type results.
- R7: In the parameter word, bits 3:0 are returned as the resource kind (0 memory, 1 I/O) and bits 18:16 as the packet type (0 memory, 2 I/O). All other bits of that word are dropped.
- R8: The write address selects entry i at byte address i*0x20 (upper bits = index, low 5 bits = byte offset). The byte offsets are 0x00 source low, 0x04 source high, 0x08 translated low, 0x0C translated high and 0x10 parameters. A write to any other offset, unaligned ones included, changes nothing.
- R9: A lookup presented in cycle N is answered in cycle N+1, with rs_valid=1 in that cycle only. A write in the same cycle as a lookup is not seen by that lookup, but is seen by one in the next cycle.
- R10: On a miss, rs_hit=0, rs_addr equals the lookup address, and both type fields are 0.
- R11: After reset every entry is disabled and rs_valid, rs_hit, rs_addr and the type outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 8 | Byte address: entry index in bits 7:5, offset in bits 4:0 |
| cfg_wdata | input | 32 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | CPU-side address to translate |
| rs_valid | output | 1 | Result valid, one cycle after lk_valid |
| rs_hit | output | 1 | An enabled window covered the address |
| rs_addr | output | 32 | Translated address, or the lookup address on a miss |
| rs_kind | output | 4 | Resource kind of the winning window |
| rs_tlp | output | 3 | Packet type of the winning window |

## Verification
The bench probes both ends of each window. An off-by-one in the mask would either let the byte past the end hit or lose the last byte. It sets up overlapping windows and then disables the lower one: a reversed priority encoder would return the higher window's translated base and I/O types. It writes a size code below the 4 KiB floor with junk in the low base bits, and a full-space code. A design without the clamp, or one that compares low base bits, would miss addresses it should cover. It also writes to the upper-half words and to an unaligned offset, and issues a lookup in the same cycle as a write. Decoding only word bits, or bypassing the table write into the lookup, would then show up as a spurious hit or a changed translation.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int XLAT_AW      = 32;
    localparam int MIN_WIN_LOG2 = 12;

    // byte offsets inside one table entry
    localparam int OFS_SRC_LO = 'h00;
    localparam int OFS_SRC_HI = 'h04;
    localparam int OFS_DST_LO = 'h08;
    localparam int OFS_DST_HI = 'h0C;
    localparam int OFS_PARAM  = 'h10;

    typedef struct packed {
        logic [XLAT_AW-1:0] src_lo;
        logic [XLAT_AW-1:0] src_hi;
        logic [XLAT_AW-1:0] dst_lo;
        logic [XLAT_AW-1:0] dst_hi;
        logic [3:0]         kind;
        logic [2:0]         tlp;
    } xlat_entry_t;

    typedef struct packed {
        logic               hit;
        logic [XLAT_AW-1:0] addr;
        logic [3:0]         kind;
        logic [2:0]         tlp;
    } xlat_result_t;

    typedef struct packed {
        logic         valid;
        xlat_result_t res;
    } xlat_out_t;

    // ones in every bit position that lies inside the window
    function automatic logic [XLAT_AW-1:0] win_offset_mask(input logic [5:0] code);
        logic [6:0]         lg;
        logic [XLAT_AW:0]   one_hot;
        lg = {1'b0, code} + 7'd1;
        if (lg < 7'(MIN_WIN_LOG2)) lg = 7'(MIN_WIN_LOG2);
        if (lg >= 7'(XLAT_AW)) begin
            return '1;
        end
        one_hot = (XLAT_AW+1)'(1) << lg;
        return XLAT_AW'(one_hot - (XLAT_AW+1)'(1));
    endfunction

endpackage

// File: rtl/xlat_entry_regs.sv
module xlat_entry_regs
    import xlat_pkg::*;
#(
    parameter  int NUM_WIN  = 8,
    parameter  int STRIDE_B = 32,
    localparam int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int OFF_W    = $clog2(STRIDE_B)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [OFF_W-1:0]                 wr_off,
    input  logic [XLAT_AW-1:0]               wr_data,
    output logic [NUM_WIN-1:0][XLAT_AW-1:0]  src_lo_o,
    output logic [NUM_WIN-1:0][XLAT_AW-1:0]  dst_lo_o,
    output logic [NUM_WIN-1:0][3:0]          kind_o,
    output logic [NUM_WIN-1:0][2:0]          tlp_o
);

    xlat_entry_t [NUM_WIN-1:0] tbl_d, tbl_q;
    logic                      off_legal;

    always_comb begin
        off_legal = (wr_off == OFF_W'(OFS_SRC_LO)) || (wr_off == OFF_W'(OFS_SRC_HI)) ||
                    (wr_off == OFF_W'(OFS_DST_LO)) || (wr_off == OFF_W'(OFS_DST_HI)) ||
                    (wr_off == OFF_W'(OFS_PARAM));
        tbl_d = tbl_q;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                case (wr_off)
                    OFF_W'(OFS_SRC_LO): tbl_d[i].src_lo = wr_data;
                    OFF_W'(OFS_SRC_HI): tbl_d[i].src_hi = wr_data;
                    OFF_W'(OFS_DST_LO): tbl_d[i].dst_lo = wr_data;
                    OFF_W'(OFS_DST_HI): tbl_d[i].dst_hi = wr_data;
                    OFF_W'(OFS_PARAM): begin
                        tbl_d[i].kind = wr_data[3:0];
                        tbl_d[i].tlp  = wr_data[18:16];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_out
        assign src_lo_o[i] = tbl_q[i].src_lo;
        assign dst_lo_o[i] = tbl_q[i].dst_lo;
        assign kind_o[i]   = tbl_q[i].kind;
        assign tlp_o[i]    = tbl_q[i].tlp;

        // R7: parameter word fields land in the addressed entry
        p_param_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(i) && wr_off == OFF_W'(OFS_PARAM)) |=>
            (tbl_q[i].kind == $past(wr_data[3:0]) && tbl_q[i].tlp == $past(wr_data[18:16])));

        // R6: upper words are kept even though lookups ignore them
        p_src_hi_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(i) && wr_off == OFF_W'(OFS_SRC_HI)) |=>
            (tbl_q[i].src_hi == $past(wr_data)));
        p_dst_hi_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(i) && wr_off == OFF_W'(OFS_DST_HI)) |=>
            (tbl_q[i].dst_hi == $past(wr_data)));

        // R8: writes to an undefined offset leave the entry untouched
        p_bad_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(i) && !off_legal) |=> $stable(tbl_q[i]));
    end

endmodule

// File: rtl/xlat_window_match.sv
module xlat_window_match
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [XLAT_AW-1:0]               lk_addr,
    input  logic [NUM_WIN-1:0][XLAT_AW-1:0]  src_lo_i,
    input  logic [NUM_WIN-1:0][XLAT_AW-1:0]  dst_lo_i,
    output logic [NUM_WIN-1:0]               match_o,
    output logic [NUM_WIN-1:0][XLAT_AW-1:0]  xaddr_o
);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic [XLAT_AW-1:0] ofs_mask;
        always_comb begin
            ofs_mask   = win_offset_mask(src_lo_i[i][6:1]);
            match_o[i] = src_lo_i[i][0] && (((lk_addr ^ src_lo_i[i]) & ~ofs_mask) == '0);
            xaddr_o[i] = (dst_lo_i[i] & ~ofs_mask) | (lk_addr & ofs_mask);
        end
    end

endmodule

// File: rtl/xlat_prio_select.sv
module xlat_prio_select
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [XLAT_AW-1:0]               lk_addr,
    input  logic [NUM_WIN-1:0]               match_i,
    input  logic [NUM_WIN-1:0][XLAT_AW-1:0]  xaddr_i,
    input  logic [NUM_WIN-1:0][3:0]          kind_i,
    input  logic [NUM_WIN-1:0][2:0]          tlp_i,
    output xlat_result_t                     res_o
);

    logic [NUM_WIN-1:0] grant;

    always_comb begin
        grant      = match_i & (~match_i + NUM_WIN'(1));
        res_o      = '0;
        res_o.hit  = |grant;
        res_o.addr = (|grant) ? '0 : lk_addr;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (grant[i]) begin
                res_o.addr = res_o.addr | xaddr_i[i];
                res_o.kind = res_o.kind | kind_i[i];
                res_o.tlp  = res_o.tlp  | tlp_i[i];
            end
        end
    end

    // R3: at most one winner, it is a matching entry and no lower one matches
    p_one_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_winner_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~match_i) == '0));
    p_winner_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((match_i & (grant - NUM_WIN'(1))) == '0));
    // R1: any match yields a winner
    p_match_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i != '0) |-> (grant != '0));

endmodule

// File: rtl/xlat_window_table.sv
module xlat_window_table
    import xlat_pkg::*;
#(
    parameter  int NUM_WIN  = 8,
    parameter  int STRIDE_B = 32,
    localparam int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int OFF_W    = $clog2(STRIDE_B),
    localparam int CFG_AW   = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic [31:0]       rs_addr,
    output logic [3:0]        rs_kind,
    output logic [2:0]        rs_tlp
);

    logic [NUM_WIN-1:0][XLAT_AW-1:0] src_lo, dst_lo, xaddr;
    logic [NUM_WIN-1:0][3:0]         kind;
    logic [NUM_WIN-1:0][2:0]         tlp;
    logic [NUM_WIN-1:0]              match;
    xlat_result_t                    sel_res;
    xlat_out_t                       out_d, out_q;

    xlat_entry_regs #(.NUM_WIN(NUM_WIN), .STRIDE_B(STRIDE_B)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_addr[CFG_AW-1:OFF_W]),
        .wr_off   (cfg_addr[OFF_W-1:0]),
        .wr_data  (cfg_wdata),
        .src_lo_o (src_lo),
        .dst_lo_o (dst_lo),
        .kind_o   (kind),
        .tlp_o    (tlp)
    );

    xlat_window_match #(.NUM_WIN(NUM_WIN)) u_match (
        .lk_addr  (lk_addr),
        .src_lo_i (src_lo),
        .dst_lo_i (dst_lo),
        .match_o  (match),
        .xaddr_o  (xaddr)
    );

    xlat_prio_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_addr  (lk_addr),
        .match_i  (match),
        .xaddr_i  (xaddr),
        .kind_i   (kind),
        .tlp_i    (tlp),
        .res_o    (sel_res)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = lk_valid;
        if (lk_valid) out_d.res = sel_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rs_valid = out_q.valid;
    assign rs_hit   = out_q.res.hit;
    assign rs_addr  = out_q.res.addr;
    assign rs_kind  = out_q.res.kind;
    assign rs_tlp   = out_q.res.tlp;

    // R9: result valid exactly one cycle after a lookup
    p_valid_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);
    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);
    // R10: a miss passes the address through with cleared types
    p_miss_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rs_hit || rs_addr == $past(lk_addr)));
    p_miss_types_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_kind == 4'd0 && rs_tlp == 3'd0));

endmodule

// File: tb/xlat_window_table_bench.sv
module xlat_window_table_bench;

    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rs_valid, rs_hit;
    logic [31:0] rs_addr;
    logic [3:0]  rs_kind;
    logic [2:0]  rs_tlp;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural table model
    logic [31:0] m_src [NW];
    logic [31:0] m_dst [NW];
    logic [3:0]  m_kind[NW];
    logic [2:0]  m_tlp [NW];

    always #2 clk = ~clk;

    xlat_window_table u_xlat_window_table (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_addr(rs_addr),
        .rs_kind(rs_kind), .rs_tlp(rs_tlp)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void ref_lookup(input logic [31:0] a, output logic h,
                                       output logic [31:0] xa, output logic [3:0] k,
                                       output logic [2:0] t);
        h = 1'b0; xa = a; k = '0; t = '0;
        for (int i = NW-1; i >= 0; i--) begin
            int              lg;
            longint unsigned sz;
            logic [31:0]     ofs;
            lg = int'(m_src[i][6:1]) + 1;
            if (lg < 12) lg = 12;
            sz  = (lg >= 32) ? 64'h1_0000_0000 : (64'd1 << lg);
            ofs = 32'(sz - 1);
            if (m_src[i][0] && ((a & ~ofs) == (m_src[i] & ~ofs))) begin
                h = 1'b1; xa = (m_dst[i] & ~ofs) | (a & ofs);
                k = m_kind[i]; t = m_tlp[i];
            end
        end
    endfunction

    function automatic void model_write(input logic [7:0] wa, input logic [31:0] wd);
        int e;
        e = int'(wa[7:5]);
        case (wa[4:0])
            5'h00: m_src[e] = wd;
            5'h08: m_dst[e] = wd;
            5'h10: begin m_kind[e] = wd[3:0]; m_tlp[e] = wd[18:16]; end
            default: ;
        endcase
    endfunction

    // one clock: drive at the falling edge, compare just after the rising edge
    task automatic step(input bit we, input logic [7:0] wa, input logic [31:0] wd,
                        input bit lv, input logic [31:0] la, input string tag);
        logic eh; logic [31:0] ea; logic [3:0] ek; logic [2:0] et;
        cfg_we = we; cfg_addr = wa; cfg_wdata = wd; lk_valid = lv; lk_addr = la;
        ref_lookup(la, eh, ea, ek, et);
        @(posedge clk);
        if (we) model_write(wa, wd);
        #1;
        chk(tag, "valid", 32'(rs_valid), 32'(lv));
        if (lv) begin
            chk(tag, "hit",  32'(rs_hit),  32'(eh));
            chk(tag, "addr", rs_addr,      ea);
            chk(tag, "kind", 32'(rs_kind), 32'(ek));
            chk(tag, "tlp",  32'(rs_tlp),  32'(et));
        end
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
    endtask

    task automatic wr(input int e, input logic [4:0] off, input logic [31:0] d, input string tag);
        step(1'b1, {3'(e), off}, d, 1'b0, '0, tag);
    endtask

    task automatic lk(input logic [31:0] a, input string tag);
        step(1'b0, '0, '0, 1'b1, a, tag);
    endtask

    function automatic logic [31:0] srcw(input logic [31:0] base, input int code, input bit en);
        return base | (32'(code) << 1) | 32'(en);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            m_src[i] = '0; m_dst[i] = '0; m_kind[i] = '0; m_tlp[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "reset valid", 32'(rs_valid), 0);
        chk("R11", "reset hit",   32'(rs_hit),   0);
        chk("R11", "reset addr",  rs_addr,       0);
        chk("R11", "reset types", {25'd0, rs_kind, rs_tlp}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        lk(32'h8000_0000, "R11");                     // empty table: miss
        lk(32'h1234_5678, "R10");

        // entry 0: 1 MiB window at 0x8000_0000; lookups in the write cycles
        step(1'b1, 8'h00, srcw(32'h8000_0000, 19, 1'b1), 1'b1, 32'h8000_0010, "R9");
        step(1'b1, 8'h08, 32'h1000_0000, 1'b1, 32'h8000_0010, "R9");
        wr(0, 5'h10, 32'h0000_0000, "R7");
        lk(32'h8001_2340, "R1");
        lk(32'h8000_0000, "R2");
        lk(32'h800F_FFFF, "R2");
        lk(32'h8010_0000, "R2");
        lk(32'h7FFF_FFFF, "R2");
        step(1'b0, '0, '0, 1'b0, 32'h8000_0000, "R9");  // idle: no valid

        // entry 1: 64 KiB I/O window at 0, junk in the spare parameter bits
        wr(1, 5'h00, srcw(32'h0000_0000, 15, 1'b1), "R8");
        wr(1, 5'h08, 32'h2000_0000, "R8");
        wr(1, 5'h10, 32'hA5A2_5A51, "R7");
        lk(32'h0000_1234, "R7");
        wr(1, 5'h04, 32'hFFFF_FFFF, "R6");
        wr(1, 5'h0C, 32'h1234_5678, "R6");
        lk(32'h0000_1234, "R6");
        lk(32'h0001_0000, "R6");

        // overlapping entries 2 and 5
        wr(2, 5'h00, srcw(32'h4000_0000, 27, 1'b1), "R3");
        wr(2, 5'h08, 32'hA000_0000, "R3");
        wr(5, 5'h00, srcw(32'h4010_0000, 19, 1'b1), "R3");
        wr(5, 5'h08, 32'hC000_0000, "R3");
        wr(5, 5'h10, 32'h0002_0001, "R3");
        lk(32'h4010_0040, "R3");
        wr(2, 5'h00, srcw(32'h4000_0000, 27, 1'b0), "R4");
        lk(32'h4010_0040, "R4");
        lk(32'h4020_0000, "R4");

        // entry 3: code below the floor, junk in low base bits
        wr(3, 5'h00, srcw(32'h9000_0000 | (32'h15 << 7), 3, 1'b1), "R5");
        wr(3, 5'h08, 32'h5000_0FFF, "R5");
        lk(32'h9000_0FFF, "R5");
        lk(32'h9000_0000, "R5");
        lk(32'h9000_1000, "R5");

        // unaligned write to disabled entry 7 must not land
        wr(7, 5'h01, 32'hFFFF_0001, "R8");
        wr(7, 5'h14, 32'hFFFF_0001, "R8");
        lk(32'hFFFF_0010, "R8");

        // entry 7 covers everything, lowest priority
        wr(7, 5'h00, srcw(32'h1234_5000, 31, 1'b1), "R5");
        wr(7, 5'h10, 32'h0002_0001, "R5");
        lk(32'hFFFF_FFF0, "R5");
        lk(32'h4020_0000, "R5");
        lk(32'h4010_0040, "R3");
        lk(32'h8000_0004, "R3");

        summary();
        $finish;
    end

endmodule